// File: doc/BRIEF.md
# DDR SDRAM Bank Command Timing Checker

This block watches the command pins of a four-bank DDR SDRAM (clock enable, chip select, row strobe, column strobe, write enable, bank address and address bit 10) and keeps a small model of every bank: idle, open, precharging, or locked in a burst that closes itself. For each sampled command it reports a decoded command code. It also reports whether the command breaks the command table for the current bank state or comes too soon after an earlier command. The minimum spacings are parameters counted in clock cycles.

It sits beside a memory controller or a bus model as a passive protocol monitor. A violation raises a one-cycle flag with a reason code and the bank concerned. The bank model still takes the command as if the memory had obeyed it, so one mistake does not turn into a long run of false reports. Every output is registered: a command sampled at clock edge n shows up after edge n.

Top module: `ddr_cmd_checker`

## Requirements
- R1: The command code is output one cycle after sampling. Codes are: 0 deselect (chip select high), 1 NOP, 2 burst stop, 3 READ, 4 WRITE, 5 ACT, 6 PRE, 7 REF, 8 mode register write, 9 CKE falling (CKE low while it was high on the edge before). While CKE was low on the previous edge the code is 1. The sampled CKE resets low, and cmd_o resets to 0.
- R2: ACT to bank b sets bank b to open. Each bank has a 2-bit state at bank_state_o[2b+1:2b]: 0 idle, 1 open, 2 precharging, 3 auto-precharge.
- R3: ACT to a bank that is open or precharging gives reason 1. READ or WRITE to an idle or precharging bank gives reason 2 and leaves the bank state unchanged.
- R4: READ or WRITE with A10 high to an open bank enters state 3. The bank returns to idle BURST+T_RP cycles after a READ, or BURST+T_WR+T_RP cycles after a WRITE. Any command aimed at a bank in state 3, including a precharge-all, gives reason 3.
- R5: PRE moves an open target bank to state 2, and that bank returns to idle T_RP cycles later. With A10 high every open bank is precharged and BA has no effect.
- R6: REF, a mode register write or CKE falling while any bank is not idle gives reason 4. The bank reported is the lowest-numbered bank that is not idle.
- R7: READ/WRITE fewer than T_RCD cycles after ACT to that bank gives reason 5. PRE to an open bank fewer than T_RAS cycles after its ACT gives reason 6.
- R8: ACT fewer than T_RC cycles after the previous ACT to the same bank gives reason 7. ACT fewer than T_RRD cycles after any ACT gives reason 8.
- R9: PRE to an open bank fewer than BURST+T_WR cycles after a WRITE to it gives reason 9.
- R10: Any command other than deselect, NOP or burst stop fewer than T_RFC cycles after REF gives reason 10, or fewer than T_MRD cycles after a mode register write gives reason 11.
- R11: A violation raises viol_o for the one output cycle of that command, with viol_code_o set to the lowest applicable reason number. The bank state still updates as if the command had been accepted. Intervals count edges: commands at edges n and n+k break a limit L when k < L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | Address bit 10 (auto-precharge / all banks) |
| cmd_o | output | 4 | Decoded command code |
| bank_state_o | output | 8 | Per-bank 2-bit state |
| viol_o | output | 1 | Violation pulse |
| viol_code_o | output | 4 | Violation reason |
| viol_bank_o | output | 2 | Bank tied to the violation |

## Verification
A bank's auto-precharge countdown can retire on the same edge that a new command names that bank. The bench provokes this by issuing ACT on exactly the edge where the dwell counter reaches its last count. That ACT must still see state 3 and report reason 3. In a separate run the ACT comes one cycle later; it must find the bank idle and report only the row-cycle reason 7.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;
  typedef enum logic [3:0] {
    C_DESEL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_RD = 4'd3, C_WR = 4'd4,
    C_ACT = 4'd5, C_PRE = 4'd6, C_REF = 4'd7, C_MRS = 4'd8, C_CKE_LO = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0, B_OPEN = 2'd1, B_PRECHG = 2'd2, B_AUTOPRE = 2'd3
  } bank_st_e;

  localparam logic [3:0] V_NONE      = 4'd0;
  localparam logic [3:0] V_ACT_BUSY  = 4'd1;
  localparam logic [3:0] V_COL_SHUT  = 4'd2;
  localparam logic [3:0] V_AP_LOCK   = 4'd3;
  localparam logic [3:0] V_NOT_IDLE  = 4'd4;
  localparam logic [3:0] V_RCD       = 4'd5;
  localparam logic [3:0] V_RAS       = 4'd6;
  localparam logic [3:0] V_RC        = 4'd7;
  localparam logic [3:0] V_RRD       = 4'd8;
  localparam logic [3:0] V_WREC      = 4'd9;
  localparam logic [3:0] V_RFC       = 4'd10;
  localparam logic [3:0] V_MRD       = 4'd11;

  function automatic logic is_real(cmd_e c);
    return !(c inside {C_DESEL, C_NOP, C_BST});
  endfunction
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_chk_pkg::*;
(
  input  logic cke_i,
  input  logic cke_q_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke_q_i)    cmd_o = C_NOP;
    else if (!cke_i) cmd_o = C_CKE_LO;
    else if (cs_ni)  cmd_o = C_DESEL;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = C_NOP;
        3'b110:  cmd_o = C_BST;
        3'b101:  cmd_o = C_RD;
        3'b100:  cmd_o = C_WR;
        3'b011:  cmd_o = C_ACT;
        3'b010:  cmd_o = C_PRE;
        3'b001:  cmd_o = C_REF;
        default: cmd_o = C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
  parameter int GAP = 2,
  localparam int W = $clog2(GAP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= W'(GAP - 1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
  import ddr_chk_pkg::*;
#(
  parameter int BURST = 2,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 8,
  parameter int T_RC  = 11,
  parameter int T_WR  = 3,
  localparam int RD_AP = BURST + T_RP,
  localparam int WR_AP = BURST + T_WR + T_RP,
  localparam int WREC  = BURST + T_WR,
  localparam int DW    = $clog2(WR_AP + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cmd_e       cmd_i,
  input  logic       sel_i,
  input  logic       pall_i,
  input  logic       ap_i,
  output bank_st_e   state_o,
  output logic [3:0] code_o
);
  bank_st_e st_q, st_d;
  logic [DW-1:0] dwell_q, dwell_d;
  logic act, col, pre, wr_go;
  logic rcd_busy, ras_busy, rc_busy, wr_busy;

  assign act   = (cmd_i == C_ACT) && sel_i;
  assign col   = (cmd_i == C_RD || cmd_i == C_WR) && sel_i;
  assign pre   = (cmd_i == C_PRE) && (sel_i || pall_i);
  assign wr_go = col && (cmd_i == C_WR) && (st_q == B_OPEN);

  ddr_gap_timer #(.GAP(T_RCD)) i_rcd (.clk_i, .rst_ni, .load_i(act),   .busy_o(rcd_busy));
  ddr_gap_timer #(.GAP(T_RAS)) i_ras (.clk_i, .rst_ni, .load_i(act),   .busy_o(ras_busy));
  ddr_gap_timer #(.GAP(T_RC))  i_rc  (.clk_i, .rst_ni, .load_i(act),   .busy_o(rc_busy));
  ddr_gap_timer #(.GAP(WREC))  i_wr  (.clk_i, .rst_ni, .load_i(wr_go), .busy_o(wr_busy));

  always_comb begin
    st_d    = st_q;
    dwell_d = (dwell_q != '0) ? dwell_q - DW'(1) : '0;
    if ((st_q == B_PRECHG || st_q == B_AUTOPRE) && dwell_q == DW'(1)) st_d = B_IDLE;
    if (act) begin
      st_d    = B_OPEN;
      dwell_d = '0;
    end else if (col && st_q == B_OPEN && ap_i) begin
      st_d    = B_AUTOPRE;
      dwell_d = (cmd_i == C_WR) ? DW'(WR_AP - 1) : DW'(RD_AP - 1);
    end else if (pre && st_q == B_OPEN) begin
      st_d    = (T_RP > 1) ? B_PRECHG : B_IDLE;
      dwell_d = DW'(T_RP - 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      dwell_q <= '0;
    end else begin
      st_q    <= st_d;
      dwell_q <= dwell_d;
    end
  end

  always_comb begin
    code_o = V_NONE;
    if (act) begin
      if (st_q == B_AUTOPRE)    code_o = V_AP_LOCK;
      else if (st_q != B_IDLE)  code_o = V_ACT_BUSY;
      else if (rc_busy)         code_o = V_RC;
    end else if (col) begin
      if (st_q == B_AUTOPRE)    code_o = V_AP_LOCK;
      else if (st_q != B_OPEN)  code_o = V_COL_SHUT;
      else if (rcd_busy)        code_o = V_RCD;
    end else if (pre) begin
      if (st_q == B_AUTOPRE)    code_o = V_AP_LOCK;
      else if (st_q == B_OPEN) begin
        if (ras_busy)           code_o = V_RAS;
        else if (wr_busy)       code_o = V_WREC;
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/ddr_cmd_checker.sv
module ddr_cmd_checker
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST = 2,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RAS = 8,
  parameter int T_RC  = 11,
  parameter int T_RRD = 2,
  parameter int T_WR  = 3,
  parameter int T_RFC = 14,
  parameter int T_MRD = 2,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic                   cs_ni,
  input  logic                   ras_ni,
  input  logic                   cas_ni,
  input  logic                   we_ni,
  input  logic [BA_W-1:0]        ba_i,
  input  logic                   a10_i,
  output logic [3:0]             cmd_o,
  output logic [2*NUM_BANKS-1:0] bank_state_o,
  output logic                   viol_o,
  output logic [3:0]             viol_code_o,
  output logic [BA_W-1:0]        viol_bank_o
);
  logic cke_q;
  cmd_e cmd;
  bank_st_e   st    [NUM_BANKS];
  logic [3:0] bcode [NUM_BANKS];
  logic rrd_busy, rfc_busy, mrd_busy;
  logic any_busy;
  logic [BA_W-1:0] busy_bank, best_bank;
  logic [3:0] gcode, best_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  ddr_cmd_decode i_decode (
    .cke_i, .cke_q_i(cke_q), .cs_ni, .ras_ni, .cas_ni, .we_ni, .cmd_o(cmd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr_bank_track #(
      .BURST(BURST), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_WR(T_WR)
    ) i_track (
      .clk_i, .rst_ni,
      .cmd_i  (cmd),
      .sel_i  (ba_i == BA_W'(b)),
      .pall_i (a10_i),
      .ap_i   (a10_i),
      .state_o(st[b]),
      .code_o (bcode[b])
    );
    assign bank_state_o[2*b +: 2] = st[b];
  end

  ddr_gap_timer #(.GAP(T_RRD)) i_rrd (.clk_i, .rst_ni, .load_i(cmd == C_ACT), .busy_o(rrd_busy));
  ddr_gap_timer #(.GAP(T_RFC)) i_rfc (.clk_i, .rst_ni, .load_i(cmd == C_REF), .busy_o(rfc_busy));
  ddr_gap_timer #(.GAP(T_MRD)) i_mrd (.clk_i, .rst_ni, .load_i(cmd == C_MRS), .busy_o(mrd_busy));

  always_comb begin
    any_busy  = 1'b0;
    busy_bank = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (st[b] != B_IDLE) begin
        any_busy  = 1'b1;
        busy_bank = BA_W'(b);
      end
    end
  end

  always_comb begin
    gcode = V_NONE;
    if (cmd inside {C_REF, C_MRS, C_CKE_LO} && any_busy) gcode = V_NOT_IDLE;
    else if (cmd == C_ACT && rrd_busy)                   gcode = V_RRD;
    else if (is_real(cmd) && rfc_busy)                   gcode = V_RFC;
    else if (is_real(cmd) && mrd_busy)                   gcode = V_MRD;
  end

  // lowest reason number wins; ties go to the global check, then the lowest bank
  always_comb begin
    best_code = gcode;
    best_bank = (gcode == V_NOT_IDLE) ? busy_bank : ba_i;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bcode[b] != V_NONE && (best_code == V_NONE || bcode[b] < best_code)) begin
        best_code = bcode[b];
        best_bank = BA_W'(b);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o       <= C_DESEL;
      viol_o      <= 1'b0;
      viol_code_o <= V_NONE;
      viol_bank_o <= '0;
    end else begin
      cmd_o       <= cmd;
      viol_o      <= (best_code != V_NONE);
      viol_code_o <= best_code;
      viol_bank_o <= best_bank;
    end
  end
endmodule

// File: rtl/ddr_cmd_checker_sva.sv
module ddr_cmd_checker_sva
  import ddr_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [BA_W-1:0]        ba_i,
  input logic                   a10_i,
  input logic [3:0]             cmd_o,
  input logic [2*NUM_BANKS-1:0] bank_state_o,
  input logic                   viol_o
);
  logic [BA_W-1:0] ba_q;
  logic a10_q;
  logic [1:0] tgt_st;
  logic any_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ba_q  <= '0;
      a10_q <= 1'b0;
    end else begin
      ba_q  <= ba_i;
      a10_q <= a10_i;
    end
  end

  assign tgt_st = bank_state_o[{ba_q, 1'b0} +: 2];

  always_comb begin
    any_open = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_state_o[2*b +: 2] == B_OPEN) any_open = 1'b1;
  end

  // R11
  viol_on_real_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> !(cmd_o inside {C_DESEL, C_NOP, C_BST}));

  // R2
  act_opens_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_ACT) |-> (tgt_st == B_OPEN));

  // R3
  clean_col_on_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o == C_RD || cmd_o == C_WR) && !viol_o) |-> (tgt_st == B_OPEN || tgt_st == B_AUTOPRE));

  // R5
  clean_pall_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_PRE && a10_q && !viol_o) |-> !any_open);

  // R6
  clean_ref_all_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == C_REF && !viol_o) |-> (bank_state_o == '0));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ap
    // R4
    ap_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_state_o[2*b +: 2] == B_AUTOPRE) |=>
        (bank_state_o[2*b +: 2] inside {B_AUTOPRE, B_IDLE} || viol_o));
  end
endmodule

bind ddr_cmd_checker ddr_cmd_checker_sva #(.NUM_BANKS(NUM_BANKS)) i_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .ba_i(ba_i), .a10_i(a10_i),
  .cmd_o(cmd_o), .bank_state_o(bank_state_o), .viol_o(viol_o)
);

// File: tb/test_ddr_cmd_checker.sv
module test_ddr_cmd_checker;
  localparam int CLK_P = 10;
  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic [3:0] cmd_o, viol_code;
  logic [7:0] bank_st;
  logic viol;
  logic [1:0] viol_bank;
  int total = 0, bad = 0;

  ddr_cmd_checker i_ddr_cmd_checker (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .a10_i(a10), .cmd_o(cmd_o),
    .bank_state_o(bank_st), .viol_o(viol), .viol_code_o(viol_code), .viol_bank_o(viol_bank)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int st(input int b);
    return int'(bank_st[2*b +: 2]);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] k, input int b, input logic ap);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = k; ba = 2'(b); a10 = ap;
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111; ba = '0; a10 = 1'b0;
  endtask

  task automatic expect_v(input string tag, input int code, input int b);
    check({tag, " flag"}, int'(viol), 1);
    check({tag, " code"}, int'(viol_code), code);
    check({tag, " bank"}, int'(viol_bank), b);
  endtask

  task automatic expect_ok(input string tag);
    check({tag, " no flag"}, int'(viol), 0);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; cke = 1'b1;
    cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111; ba = '0; a10 = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    idle(1);
    check("R1 reset cmd", int'(cmd_o), 0);
    check("R2 reset states", int'(bank_st), 0);
    check("R11 reset flag", int'(viol), 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 nop decode", int'(cmd_o), 1);
  endtask

  task automatic t_rcd;
    do_reset();
    issue(K_ACT, 0, 0);
    check("R1 act code", int'(cmd_o), 5);
    check("R2 bank0 open", st(0), 1);
    expect_ok("R2 act");
    idle(1);
    issue(K_RD, 0, 0);
    check("R1 rd code", int'(cmd_o), 3);
    expect_v("R7 rcd", 5, 0);
    issue(K_RD, 0, 0);
    expect_ok("R7 rcd boundary");
    idle(1);
    expect_ok("R11 pulse ends");
  endtask

  task automatic t_illegal;
    do_reset();
    issue(K_ACT, 0, 0);
    idle(2);
    issue(K_ACT, 0, 0);
    expect_v("R3 act open bank", 1, 0);
    issue(K_RD, 2, 0);
    expect_v("R3 rd idle bank", 2, 2);
    check("R3 bank2 untouched", st(2), 0);
  endtask

  task automatic t_ras_pre;
    do_reset();
    issue(K_ACT, 1, 0);
    idle(2);
    issue(K_PRE, 1, 0);
    expect_v("R7 ras", 6, 1);
    check("R5 precharging", st(1), 2);
    idle(1);
    check("R5 still precharging", st(1), 2);
    idle(1);
    check("R5 back idle", st(1), 0);
  endtask

  task automatic t_pall_ignore_ba;
    do_reset();
    issue(K_ACT, 3, 0);
    idle(8);
    issue(K_PRE, 0, 1);
    expect_ok("R5 pall");
    check("R5 pall ignores ba", st(3), 2);
    check("R6 pre code", int'(cmd_o), 6);
  endtask

  task automatic t_rrd;
    do_reset();
    issue(K_ACT, 2, 0);
    issue(K_ACT, 3, 0);
    expect_v("R8 rrd", 8, 3);
    check("R11 state updates", st(3), 1);
  endtask

  // auto-precharge retires on the same edge the next ACT arrives
  task automatic t_ap_race;
    do_reset();
    issue(K_ACT, 0, 0);
    idle(2);
    issue(K_RD, 0, 1);
    expect_ok("R4 rd ap");
    check("R4 ap state", st(0), 3);
    idle(3);
    check("R4 ap held", st(0), 3);
    issue(K_ACT, 0, 0);
    expect_v("R4 ap race", 3, 0);
    check("R11 act taken", st(0), 1);
  endtask

  task automatic t_ap_rc;
    do_reset();
    issue(K_ACT, 0, 0);
    idle(2);
    issue(K_RD, 0, 1);
    idle(4);
    check("R4 ap done", st(0), 0);
    issue(K_ACT, 0, 0);
    expect_v("R8 rc", 7, 0);
  endtask

  task automatic t_wr_ap;
    do_reset();
    issue(K_ACT, 1, 0);
    idle(2);
    issue(K_WR, 1, 1);
    check("R1 wr code", int'(cmd_o), 4);
    idle(6);
    check("R4 wr ap held", st(1), 3);
    idle(1);
    check("R4 wr ap done", st(1), 0);
  endtask

  task automatic t_wrec;
    do_reset();
    issue(K_ACT, 1, 0);
    idle(5);
    issue(K_WR, 1, 0);
    expect_ok("R9 write");
    idle(1);
    issue(K_PRE, 1, 0);
    expect_v("R9 wr recovery", 9, 1);
  endtask

  task automatic t_pall_ap;
    do_reset();
    issue(K_ACT, 0, 0);
    idle(2);
    issue(K_RD, 0, 1);
    issue(K_ACT, 1, 0);
    issue(K_PRE, 2, 1);
    expect_v("R4 pall on ap bank", 3, 0);
    check("R4 ap bank kept", st(0), 3);
    check("R5 open bank closed", st(1), 2);
  endtask

  task automatic t_ref;
    do_reset();
    issue(K_ACT, 3, 0);
    issue(K_REF, 0, 0);
    expect_v("R6 ref busy", 4, 3);
    do_reset();
    issue(K_REF, 0, 0);
    check("R1 ref code", int'(cmd_o), 7);
    expect_ok("R6 ref idle");
    idle(12);
    issue(K_ACT, 0, 0);
    expect_v("R10 rfc", 10, 0);
    do_reset();
    issue(K_REF, 0, 0);
    idle(13);
    issue(K_ACT, 0, 0);
    expect_ok("R10 rfc boundary");
  endtask

  task automatic t_mrs;
    do_reset();
    issue(K_MRS, 0, 0);
    check("R1 mrs code", int'(cmd_o), 8);
    issue(K_ACT, 1, 0);
    expect_v("R10 mrd", 11, 1);
    do_reset();
    issue(K_MRS, 0, 0);
    idle(1);
    issue(K_ACT, 1, 0);
    expect_ok("R10 mrd boundary");
  endtask

  task automatic t_cke;
    do_reset();
    issue(K_ACT, 2, 0);
    idle(1);
    cke = 1'b0;
    idle(1);
    check("R1 cke fall code", int'(cmd_o), 9);
    expect_v("R6 cke busy", 4, 2);
    idle(1);
    check("R1 asleep nop", int'(cmd_o), 1);
    expect_ok("R11 one pulse");
    do_reset();
    cke = 1'b0;
    idle(1);
    expect_ok("R6 cke idle");
    cke = 1'b1;
  endtask

  initial begin
    cs_n = 1'b0;
    t_reset();
    t_rcd();
    t_illegal();
    t_ras_pre();
    t_pall_ignore_ba();
    t_rrd();
    t_ap_race();
    t_ap_rc();
    t_wr_ap();
    t_wrec();
    t_pall_ap();
    t_ref();
    t_mrs();
    t_cke();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule